// File: doc/BRIEF.md
# Program Counter with Branch Control

This block holds the instruction address of a single-cycle processor and works out the next one on every clock. Three control inputs choose among three behaviours: step forward by one, load an absolute target taken from the first register read bus, or add a signed relative displacement when the selected status flag is set. Only the relative behaviour looks at a status flag, either the negative flag or the zero flag.

The relative displacement is supplied as two 3-bit halves that sit apart in the instruction word. The block joins them, reads the 6-bit result as a two's-complement number and sign-extends it to the full counter width. The registered counter value drives the instruction memory address directly. Instruction memory, the function unit that produces the flags and the instruction decoder all sit outside this block.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_out` becomes 0 on that edge, whatever the other inputs are.
- R2: When `ld_en` is 0, `pc_out` becomes `pc_out + 1` on the next edge, whatever `jump_sel`, `cond_sel`, `neg_flag`, `zero_flag`, the offset halves and `jump_addr` are.
- R3: When `ld_en` is 1 and `jump_sel` is 1, `pc_out` becomes `jump_addr` on the next edge, whatever the flags, `cond_sel` and the offset are.
- R4: When `ld_en` is 1, `jump_sel` is 0 and `cond_sel` is 1, `pc_out` becomes `pc_out + offset` if `neg_flag` is 1. Otherwise it becomes `pc_out + 1`. `zero_flag` is ignored.
- R5: When `ld_en` is 1, `jump_sel` is 0 and `cond_sel` is 0, `pc_out` becomes `pc_out + offset` if `zero_flag` is 1. Otherwise it becomes `pc_out + 1`. `neg_flag` is ignored.
- R6: The offset is the 6-bit value {`off_hi`, `off_lo`}, with `off_hi` as the upper three bits. It is read as two's complement (-32 to +31) and sign-extended. Example: with `pc_out` = 45, `off_hi` = 3'b110 and `off_lo` = 3'b100, a taken branch gives 33.
- R7: All counter arithmetic wraps modulo 2^16 and has no overflow indication. 0xFFFF + 1 gives 0, and 2 + (-32) gives 0xFFE2.
- R8: `pc_out` is a register. A change on any control or data input between two edges leaves `pc_out` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | 0: count up; 1: jump or conditional branch |
| jump_sel | input | 1 | With `ld_en` = 1: 1 selects jump, 0 selects branch |
| cond_sel | input | 1 | For a branch: 1 tests `neg_flag`, 0 tests `zero_flag` |
| neg_flag | input | 1 | Negative status flag |
| zero_flag | input | 1 | Zero status flag |
| off_hi | input | 3 | Upper half of the branch displacement |
| off_lo | input | 3 | Lower half of the branch displacement |
| jump_addr | input | 16 | Absolute jump target from register bus A |
| pc_out | output | 16 | Current program counter |

## Verification
The bench builds the block with its default values: a 16-bit counter and two 3-bit offset halves. With these values the wrap from 0xFFFF to 0 and the full displacement range from -32 to +31 can be reached through a single jump, so the edge cases need no long runs. Swapped offset halves show up because the +8 and -32 displacements only give the expected result when the upper half is in the right place. A reference model steps through every cycle of a long mixed stream of counts, jumps and taken and untaken branches, with the ignored inputs toggling throughout.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int PC_WIDTH_DEF = 16;
    localparam int OFF_HALF_DEF = 3;

    // Action chosen for the next counter value
    typedef enum logic [1:0] {
        PC_ACT_COUNT  = 2'd0,
        PC_ACT_JUMP   = 2'd1,
        PC_ACT_BRANCH = 2'd2
    } pc_act_e;

    // Control bundle sampled each cycle
    typedef struct packed {
        logic ld_en;
        logic jump_sel;
        logic cond_sel;
        logic neg_flag;
        logic zero_flag;
    } pc_ctl_t;

    // Branch condition: selected flag is set
    function automatic logic cond_met(input pc_ctl_t c);
        return c.cond_sel ? c.neg_flag : c.zero_flag;
    endfunction

endpackage

// File: rtl/pc_offset_ext.sv
module pc_offset_ext #(
    parameter int WIDTH  = pc_pkg::PC_WIDTH_DEF,
    parameter int HALF_W = pc_pkg::OFF_HALF_DEF
) (
    input  logic [HALF_W-1:0] off_hi,
    input  logic [HALF_W-1:0] off_lo,
    output logic [WIDTH-1:0]  off_ext
);
    localparam int OFF_W = 2 * HALF_W;
    localparam int PAD_W = WIDTH - OFF_W;

    logic [OFF_W-1:0] joined;

    always_comb joined = {off_hi, off_lo};

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb off_ext = {{PAD_W{joined[OFF_W-1]}}, joined};
        end else begin : g_trunc
            always_comb off_ext = joined[WIDTH-1:0];
        end
    endgenerate
endmodule

// File: rtl/pc_branch_sel.sv
module pc_branch_sel
    import pc_pkg::*;
(
    input  pc_ctl_t ctl,
    output pc_act_e act
);
    always_comb begin
        if (!ctl.ld_en)
            act = PC_ACT_COUNT;
        else if (ctl.jump_sel)
            act = PC_ACT_JUMP;
        else if (cond_met(ctl))
            act = PC_ACT_BRANCH;
        else
            act = PC_ACT_COUNT;
    end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
    import pc_pkg::*;
#(
    parameter int WIDTH = PC_WIDTH_DEF
) (
    input  pc_act_e          act,
    input  logic [WIDTH-1:0] pc_cur,
    input  logic [WIDTH-1:0] off_ext,
    input  logic [WIDTH-1:0] jump_addr,
    output logic [WIDTH-1:0] pc_nxt
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] inc_val;
    logic [WIDTH-1:0] rel_val;

    always_comb begin
        inc_val = pc_cur + ONE;
        rel_val = pc_cur + off_ext;
        case (act)
            PC_ACT_JUMP:   pc_nxt = jump_addr;
            PC_ACT_BRANCH: pc_nxt = rel_val;
            default:       pc_nxt = inc_val;
        endcase
    end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
    import pc_pkg::*;
#(
    parameter int WIDTH  = PC_WIDTH_DEF,
    parameter int HALF_W = OFF_HALF_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              jump_sel,
    input  logic              cond_sel,
    input  logic              neg_flag,
    input  logic              zero_flag,
    input  logic [HALF_W-1:0] off_hi,
    input  logic [HALF_W-1:0] off_lo,
    input  logic [WIDTH-1:0]  jump_addr,
    output logic [WIDTH-1:0]  pc_out
);
    localparam int PAD_W = WIDTH - 2 * HALF_W;

    pc_ctl_t          ctl;
    pc_act_e          act;
    logic [WIDTH-1:0] off_ext;
    logic [WIDTH-1:0] pc_q;
    logic [WIDTH-1:0] pc_d;

    always_comb begin
        ctl.ld_en     = ld_en;
        ctl.jump_sel  = jump_sel;
        ctl.cond_sel  = cond_sel;
        ctl.neg_flag  = neg_flag;
        ctl.zero_flag = zero_flag;
    end

    pc_offset_ext #(.WIDTH(WIDTH), .HALF_W(HALF_W)) u_ext (
        .off_hi (off_hi),
        .off_lo (off_lo),
        .off_ext(off_ext)
    );

    pc_branch_sel u_sel (
        .ctl(ctl),
        .act(act)
    );

    pc_next_calc #(.WIDTH(WIDTH)) u_calc (
        .act      (act),
        .pc_cur   (pc_q),
        .off_ext  (off_ext),
        .jump_addr(jump_addr),
        .pc_nxt   (pc_d)
    );

    // R8: registered output
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    always_comb pc_out = pc_q;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc_out == '0);

    assert_count_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ld_en)) |->
        pc_out == WIDTH'($past(pc_out) + 1'b1));

    assert_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld_en) && $past(jump_sel)) |->
        pc_out == $past(jump_addr));

    assert_neg_branch_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld_en) && !$past(jump_sel) && $past(cond_sel)) |->
        pc_out == ($past(neg_flag)
            ? WIDTH'($past(pc_out) + {{PAD_W{$past(off_hi[HALF_W-1])}}, $past(off_hi), $past(off_lo)})
            : WIDTH'($past(pc_out) + 1'b1)));

    assert_zero_branch_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ld_en) && !$past(jump_sel) && !$past(cond_sel)) |->
        pc_out == ($past(zero_flag)
            ? WIDTH'($past(pc_out) + {{PAD_W{$past(off_hi[HALF_W-1])}}, $past(off_hi), $past(off_lo)})
            : WIDTH'($past(pc_out) + 1'b1)));
endmodule

// File: tb/pc_branch_unit_tb.sv
module pc_branch_unit_tb;
    localparam int W = 16;
    localparam int H = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic         ld_en, jump_sel, cond_sel, neg_flag, zero_flag;
    logic [H-1:0] off_hi, off_lo;
    logic [W-1:0] jump_addr;
    logic [W-1:0] pc_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;
    logic [W-1:0] exp_pc;

    always #5 clk = ~clk;

    pc_branch_unit #(.WIDTH(W), .HALF_W(H)) u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .jump_sel(jump_sel),
        .cond_sel(cond_sel), .neg_flag(neg_flag), .zero_flag(zero_flag),
        .off_hi(off_hi), .off_lo(off_lo), .jump_addr(jump_addr), .pc_out(pc_out)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (pc_out !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, pc_out, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic, modulo 65536
    function automatic logic [W-1:0] model_next(input logic [W-1:0] cur,
            input logic l, j, c, n, z, input logic [H-1:0] hi, lo,
            input logic [W-1:0] ja);
        int disp;
        int base;
        disp = int'(hi) * 8 + int'(lo);
        if (disp >= 32) disp = disp - 64;
        base = int'(cur);
        if (l && j) return ja;
        if (l && ((c && n) || (!c && z))) return W'((base + disp + 65536) % 65536);
        return W'((base + 1) % 65536);
    endfunction

    task automatic step(input string req, input logic l, j, c, n, z,
                        input logic [H-1:0] hi, lo, input logic [W-1:0] ja);
        ld_en = l; jump_sel = j; cond_sel = c; neg_flag = n; zero_flag = z;
        off_hi = hi; off_lo = lo; jump_addr = ja;
        exp_pc = model_next(exp_pc, l, j, c, n, z, hi, lo, ja);
        @(posedge clk); #1;
        check(req, exp_pc);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ld_en = 1'b1; jump_sel = 1'b1; cond_sel = 1'b0;
        neg_flag = 1'b1; zero_flag = 1'b1; off_hi = '0; off_lo = '0;
        jump_addr = 16'h1234;
        repeat (3) @(posedge clk);
        #1;
        exp_pc = '0;
        check("R1 reset state", 16'h0000);
        rst = 1'b0;

        // R2: count ignores all other inputs
        step("R2 count, others high", 0, 1, 1, 1, 1, 3'b111, 3'b111, 16'h1234);
        step("R2 count, others low",  0, 0, 0, 0, 0, 3'b000, 3'b001, 16'h0000);
        // R3: jump
        step("R3 jump to 45", 1, 1, 0, 0, 0, 3'b110, 3'b100, 16'd45);
        // R4 / R6: documented example 45 + (-12) = 33
        step("R6 neg taken 45-12", 1, 0, 1, 1, 0, 3'b110, 3'b100, 16'hAAAA);
        step("R4 neg not taken, zero set", 1, 0, 1, 0, 1, 3'b110, 3'b100, 16'hAAAA);
        // R5
        step("R5 zero taken +5", 1, 0, 0, 0, 1, 3'b000, 3'b101, 16'hAAAA);
        step("R5 zero not taken, neg set", 1, 0, 0, 1, 0, 3'b000, 3'b101, 16'hAAAA);
        // R6: half ordering and extreme values
        step("R6 upper half +8", 1, 0, 0, 0, 1, 3'b001, 3'b000, 16'h0);
        step("R6 most negative -32", 1, 0, 1, 1, 0, 3'b100, 3'b000, 16'h0);
        step("R6 most positive +31", 1, 0, 1, 1, 0, 3'b011, 3'b111, 16'h0);
        step("R3 jump ignores flags", 1, 1, 1, 1, 1, 3'b101, 3'b010, 16'hFFFF);
        check("R3 jump to 0xFFFF", 16'hFFFF);
        // R7: wrap
        step("R7 wrap count", 0, 0, 0, 0, 0, 3'b000, 3'b000, 16'h0);
        check("R7 0xFFFF+1", 16'h0000);
        step("R3 jump to 2", 1, 1, 0, 0, 0, 3'b000, 3'b000, 16'h0002);
        step("R7 wrap below zero", 1, 0, 1, 1, 0, 3'b100, 3'b000, 16'h0);
        check("R7 2-32", 16'hFFE2);
        step("R7 wrap forward +31", 1, 0, 0, 0, 1, 3'b011, 3'b111, 16'h0);

        // R8: mid-cycle input change must not move the output
        ld_en = 1'b1; jump_sel = 1'b1; jump_addr = 16'h5555;
        #3;
        check("R8 no change before edge", exp_pc);
        zero_flag = 1'b1; cond_sel = 1'b0; jump_sel = 1'b0; #2;
        check("R8 still held", exp_pc);
        step("R8 jump lands on edge", 1, 1, 0, 0, 0, 3'b000, 3'b000, 16'h5555);
        check("R8 value 0x5555", 16'h5555);

        // R1: reset mid-run overrides a jump
        rst = 1'b1; ld_en = 1'b1; jump_sel = 1'b1; jump_addr = 16'h7777;
        @(posedge clk); #1;
        exp_pc = '0;
        check("R1 reset over jump", 16'h0000);
        rst = 1'b0;

        // Mixed stream against the reference model
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] ja;
            logic [H-1:0] h, lo;
            logic l, j, c, n, z;
            string tag;
            {l, j, c, n, z} = 5'($urandom);
            if ((i % 7) == 0) l = 1'b0;
            h  = 3'($urandom);
            lo = 3'($urandom);
            ja = 16'($urandom);
            if (!l)      tag = "R2 stream";
            else if (j)  tag = "R3 stream";
            else if (c)  tag = "R4 stream";
            else         tag = "R5 stream";
            step(tag, l, j, c, n, z, h, lo, ja);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule